// File: doc/BRIEF.md
# Out-of-Order Read Return Tracker

This block sits on the processor side of a multiplexed system bus and keeps track of up to two read requests that are waiting for data. When a read is issued, the block stores the request's tag together with a bit that says whether it fetches instructions or data. When data beats come back, the block reports on each beat which stored request the beat belongs to, along with that request's tag and type. The request is retired after its last beat.

By default, a second read is expected to return after the first. The external agent can reverse that expectation with a level-held swap input. Each clock cycle in which the swap input is high flips the expected order once. A swap only takes effect when it leads the returning data by at least two cycles, because the swap input passes through a two-stage delay before it reaches the order flag. A swap that is still in flight when a burst begins is reported as a protocol error.

The swap input is honoured only while a configuration enable is high. The block also flags a data beat that arrives with nothing outstanding, and a read issued while both entries are already in use.

Top module: `rrt_tracker`

## Requirements
- R1: After a synchronous reset, `outstanding` is 0, no error output is high, `ret_valid` is low, and the expected order is in-order.
- R2: With no swaps, data returns are attributed oldest first. Every beat of a burst reports the tag of the oldest outstanding read, and the next burst reports the younger read.
- R3: The order is toggled once for each cycle in which `swap_in` and `swap_en` are both high. With two reads outstanding, an odd number of such cycles makes the younger read return first, and an even number leaves the order unchanged.
- R4: A swap cycle at cycle t affects a burst whose first beat is at cycle t+2 or later. A burst whose first beat comes at cycle t or t+1 raises `err_late_swap` on that first beat and uses the order from before the swap.
- R5: `ret_instr` on each beat equals the `rd_instr` value given when the matching read was issued (1 means instruction read, 0 means data read).
- R6: While `swap_en` is low, `swap_in` has no effect on attribution.
- R7: A `data_valid` beat with `outstanding` equal to 0 raises `err_orphan` in that cycle, leaves `ret_valid` low, and does not change the tracker state.
- R8: A burst is `BEATS` beats long. After its last beat the entry is retired, `outstanding` drops by one, and the remaining entry becomes the oldest with the order reset to in-order. A swap toggle that matures in the same cycle still applies.
- R9: A read issued while two reads are outstanding, with no retirement in that cycle, raises `err_overflow` and is dropped. A read issued in the cycle a retirement happens is accepted.
- R10: Asserting `rst` part-way through activity clears both entries, the beat count, the pending swaps and the order flag.
- R11: Once a burst has started, every later beat of that burst reports the same request, even if the order toggles during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swap_en | input | 1 | Configuration enable for the swap feature |
| rd_issue | input | 1 | A read request is issued this cycle |
| rd_tag | input | TAG_W | Tag of the issued read |
| rd_instr | input | 1 | 1 for an instruction read, 0 for a data read |
| swap_in | input | 1 | Level-held order swap from the external agent |
| data_valid | input | 1 | A read data beat is present this cycle |
| ret_valid | output | 1 | The current beat was matched to a request |
| ret_tag | output | TAG_W | Tag of the matched request |
| ret_instr | output | 1 | Type bit of the matched request |
| outstanding | output | 2 | Number of reads waiting for data |
| err_orphan | output | 1 | A beat arrived with no read outstanding |
| err_late_swap | output | 1 | A swap was still in the delay pipe at the start of a burst |
| err_overflow | output | 1 | A read was issued while both entries were full |

## Verification
The bench targets several timing corners, each with a distinct failure it would expose:
- A swap exactly one cycle ahead of a burst. A design without the two-stage delay would reorder that burst and miss the late flag.
- A swap held for two cycles. A design that treated the input as an edge event, not a per-cycle toggle, would end up reversed.
- A swap during a burst. A design that re-picked the entry on every beat would split the burst across two tags.
- Issue-with-retire on a full tracker. A design that tested fullness before retirement would drop a legal read.
- Orphan beats and swaps while the enable is clear. A design that leaked either into its state would show up as a wrong tag later in the run.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  localparam int unsigned RRT_ENTRIES = 2;

  // Entry that the next burst belongs to.
  function automatic logic rrt_pick(input logic [1:0] live, input logic oldest,
                                    input logic swapped);
    if (&live) return oldest ^ swapped;
    return live[0] ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [1:0] rrt_count(input logic [1:0] live);
    return {1'b0, live[0]} + {1'b0, live[1]};
  endfunction

  function automatic logic [1:0] rrt_onehot(input logic idx);
    return idx ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/rrt_swap_pipe.sv
module rrt_swap_pipe (
  input  logic clk,
  input  logic rst,
  input  logic swap_en,
  input  logic swap_in,
  input  logic retire,
  output logic swapped,
  output logic swap_inflight,
  output logic order_q_o
);
  logic stg1_q, stg2_q, order_q;
  logic swap_req;

  assign swap_req      = swap_in & swap_en;
  assign swapped       = order_q ^ stg2_q;
  assign swap_inflight = swap_req | stg1_q;
  assign order_q_o     = order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1_q  <= 1'b0;
      stg2_q  <= 1'b0;
      order_q <= 1'b0;
    end else begin
      stg1_q  <= swap_req;
      stg2_q  <= stg1_q;
      order_q <= (retire ? 1'b0 : order_q) ^ stg2_q;
    end
  end

  AST_SWAP_GATED: assert property (@(posedge clk) disable iff (rst)
    !swap_en |=> !stg1_q); // R6
  AST_ORDER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (retire && !stg2_q) |=> !order_q); // R8
  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (!retire && stg2_q) |=> (order_q != $past(order_q))); // R3
endmodule

// File: rtl/rrt_slot_table.sv
module rrt_slot_table import rrt_pkg::*; #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [TAG_W-1:0] issue_tag,
  input  logic             issue_instr,
  input  logic             retire,
  input  logic             retire_slot,
  input  logic             rd_slot,
  output logic [1:0]       live,
  output logic             oldest,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_instr,
  output logic             ovf
);
  logic [1:0]       live_q, live_after_ret, live_d;
  logic             oldest_q, oldest_d;
  logic             accept, free_slot;
  logic [TAG_W-1:0] tag_q   [RRT_ENTRIES];
  logic             instr_q [RRT_ENTRIES];

  assign live_after_ret = live_q & ~(retire ? rrt_onehot(retire_slot) : 2'b00);
  assign ovf            = issue & (&live_q) & ~retire;
  assign accept         = issue & ~ovf;
  assign free_slot      = live_after_ret[0];
  assign live_d         = live_after_ret | (accept ? rrt_onehot(free_slot) : 2'b00);

  always_comb begin
    oldest_d = oldest_q;
    if (accept && live_after_ret == 2'b00) oldest_d = free_slot;
    else if (retire && live_after_ret != 2'b00) oldest_d = live_after_ret[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= 2'b00;
      oldest_q <= 1'b0;
    end else begin
      live_q   <= live_d;
      oldest_q <= oldest_d;
    end
  end

  for (genvar g = 0; g < RRT_ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        tag_q[g]   <= '0;
        instr_q[g] <= 1'b0;
      end else if (accept && free_slot == g[0]) begin
        tag_q[g]   <= issue_tag;
        instr_q[g] <= issue_instr;
      end
    end
  end

  assign live     = live_q;
  assign oldest   = oldest_q;
  assign rd_tag   = tag_q[rd_slot];
  assign rd_instr = instr_q[rd_slot];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (live_q == $past(live_q))); // R9
  AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (rst)
    retire |-> live_q[retire_slot]); // R8
  AST_RETIRE_DROP: assert property (@(posedge clk) disable iff (rst)
    (retire && !issue) |=> (rrt_count(live_q) == rrt_count($past(live_q)) - 2'd1)); // R8
  AST_OLDEST_LIVE: assert property (@(posedge clk) disable iff (rst)
    (live_q != 2'b00) |-> live_q[oldest_q]); // R2
endmodule

// File: rtl/rrt_beat_ctr.sv
module rrt_beat_ctr #(
  parameter int unsigned BEATS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic any_live,
  input  logic pick_slot,
  output logic first,
  output logic last,
  output logic tgt_slot
);
  localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] cnt_q;
  logic              lock_q;

  assign first    = (cnt_q == '0);
  assign last     = (cnt_q == LAST_IDX);
  assign tgt_slot = first ? pick_slot : lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (first) lock_q <= pick_slot;
    end
  end

  AST_BURST_HELD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> any_live); // R11
  AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (beat && !first) |-> (tgt_slot == $past(tgt_slot))); // R11
endmodule

// File: rtl/rrt_tracker.sv
module rrt_tracker import rrt_pkg::*; #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned BEATS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             swap_en,
  input  logic             rd_issue,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_instr,
  input  logic             swap_in,
  input  logic             data_valid,
  output logic             ret_valid,
  output logic [TAG_W-1:0] ret_tag,
  output logic             ret_instr,
  output logic [1:0]       outstanding,
  output logic             err_orphan,
  output logic             err_late_swap,
  output logic             err_overflow
);
  logic [1:0] live;
  logic       oldest, swapped, swap_inflight, order_q;
  logic       any_live, beat, first, last, retire, pick, tgt;

  assign any_live = |live;
  assign beat     = data_valid & any_live;
  assign retire   = beat & last;
  assign pick     = rrt_pick(live, oldest, swapped);

  rrt_swap_pipe u_swap (
    .clk(clk), .rst(rst), .swap_en(swap_en), .swap_in(swap_in),
    .retire(retire), .swapped(swapped), .swap_inflight(swap_inflight),
    .order_q_o(order_q)
  );

  rrt_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk(clk), .rst(rst), .beat(beat), .any_live(any_live),
    .pick_slot(pick), .first(first), .last(last), .tgt_slot(tgt)
  );

  rrt_slot_table #(.TAG_W(TAG_W)) u_slots (
    .clk(clk), .rst(rst), .issue(rd_issue), .issue_tag(rd_tag),
    .issue_instr(rd_instr), .retire(retire), .retire_slot(tgt),
    .rd_slot(tgt), .live(live), .oldest(oldest), .rd_tag(ret_tag),
    .rd_instr(ret_instr), .ovf(err_overflow)
  );

  assign ret_valid     = beat;
  assign outstanding   = rrt_count(live);
  assign err_orphan    = data_valid & ~any_live;
  assign err_late_swap = beat & first & swap_inflight;

  AST_ORPHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (err_orphan && !rd_issue) |=> (outstanding == 2'd0)); // R7
  AST_ORPHAN_QUIET: assert property (@(posedge clk) disable iff (rst)
    err_orphan |-> !ret_valid); // R7
  AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (rst)
    !(err_orphan && err_late_swap)); // R4
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (outstanding == 2'd0 && !order_q)); // R10
endmodule

// File: tb/rrt_tracker_tb.sv
module rrt_tracker_tb;
  localparam int TAG_W = 4;
  localparam int BEATS = 4;

  logic clk = 1'b0;
  logic rst, swap_en, rd_issue, rd_instr, swap_in, data_valid;
  logic [TAG_W-1:0] rd_tag;
  logic ret_valid, ret_instr, err_orphan, err_late_swap, err_overflow;
  logic [TAG_W-1:0] ret_tag;
  logic [1:0] outstanding;

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference state
  logic [1:0] mv;
  logic [TAG_W-1:0] mtag [2];
  logic minstr [2];
  logic mold, mord, ms1, ms2, mcur;
  int mbeat;

  always #5 clk = ~clk;

  rrt_tracker #(.TAG_W(TAG_W), .BEATS(BEATS)) u_dut (
    .clk(clk), .rst(rst), .swap_en(swap_en), .rd_issue(rd_issue),
    .rd_tag(rd_tag), .rd_instr(rd_instr), .swap_in(swap_in),
    .data_valid(data_valid), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .ret_instr(ret_instr), .outstanding(outstanding),
    .err_orphan(err_orphan), .err_late_swap(err_late_swap),
    .err_overflow(err_overflow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int live_cnt();
    return int'(mv[0]) + int'(mv[1]);
  endfunction

  // Attribution: oldest, flipped by the committed order and by the toggle maturing now.
  function automatic logic owner(input logic flip);
    if (live_cnt() == 2) return flip ? ~mold : mold;
    return mv[0] ? 1'b0 : 1'b1;
  endfunction

  task automatic model_reset();
    mv = 2'b00; mold = 0; mord = 0; ms1 = 0; ms2 = 0; mcur = 0; mbeat = 0;
    mtag[0] = '0; mtag[1] = '0; minstr[0] = 0; minstr[1] = 0;
  endtask

  task automatic step(input logic i_rst, input logic i_en, input logic i_iss,
                      input logic [TAG_W-1:0] i_tag, input logic i_ins,
                      input logic i_sw, input logic i_dv);
    logic sw_now, first, slot, beat, retire, ovf, late, orph, f;
    logic [1:0] after;
    @(negedge clk);
    rst = i_rst; swap_en = i_en; rd_issue = i_iss; rd_tag = i_tag;
    rd_instr = i_ins; swap_in = i_sw; data_valid = i_dv;
    #2;
    sw_now = i_en & i_sw;
    beat   = i_dv && live_cnt() > 0;
    first  = (mbeat == 0);
    slot   = first ? owner(mord ^ ms2) : mcur;
    retire = beat && (mbeat == BEATS - 1);
    orph   = i_dv && live_cnt() == 0;
    late   = beat && first && (sw_now || ms1);
    ovf    = i_iss && live_cnt() == 2 && !retire;
    if (!i_rst) begin
      chk("R8", "outstanding", outstanding, live_cnt());
      chk("R7", "err_orphan", err_orphan, orph);
      chk("R9", "err_overflow", err_overflow, ovf);
      chk("R4", "err_late_swap", err_late_swap, late);
      chk(phase, "ret_valid", ret_valid, beat);
      if (beat) begin
        chk(phase, "ret_tag", ret_tag, mtag[slot]);
        chk("R5", "ret_instr", ret_instr, minstr[slot]);
      end
    end
    @(posedge clk);
    if (i_rst) begin
      model_reset();
    end else begin
      mord = (retire ? 1'b0 : mord) ^ ms2;
      ms2 = ms1; ms1 = sw_now;
      if (beat) begin
        if (first) mcur = slot;
        mbeat = retire ? 0 : mbeat + 1;
      end
      after = mv;
      if (retire) after[slot] = 1'b0;
      if (i_iss && !ovf) begin
        f = after[0];
        if (after == 2'b00) mold = f;
        else if (retire) mold = after[1];
        after[f] = 1'b1; mtag[f] = i_tag; minstr[f] = i_ins;
      end else if (retire && after != 2'b00) begin
        mold = after[1];
      end
      mv = after;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, swap_en, 0, '0, 0, 0, 0);
  endtask

  task automatic burst(input logic en);
    for (int i = 0; i < BEATS; i++) step(0, en, 0, '0, 0, 0, 1);
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    model_reset();
    rst = 1; swap_en = 0; rd_issue = 0; rd_tag = '0; rd_instr = 0;
    swap_in = 0; data_valid = 0;
    step(1, 0, 0, '0, 0, 0, 0);
    step(1, 0, 0, '0, 0, 0, 0);
    // R1: reset state
    @(negedge clk); #2;
    chk("R1", "outstanding", outstanding, 0);
    chk("R1", "ret_valid", ret_valid, 0);
    chk("R1", "errors", {err_orphan, err_late_swap, err_overflow}, 0);

    // R2 in-order, with R5 type bits
    phase = "R2";
    step(0, 1, 1, 4'h3, 1, 0, 0);
    step(0, 1, 1, 4'h9, 0, 0, 0);
    burst(1); burst(1);

    // R3 single swap cycle with enough lead
    phase = "R3";
    step(0, 1, 1, 4'h1, 0, 0, 0);
    step(0, 1, 1, 4'h2, 1, 1, 0);
    idle(2); burst(1); burst(1);
    // R3 held two cycles leaves order unchanged
    step(0, 1, 1, 4'h5, 0, 1, 0);
    step(0, 1, 1, 4'h6, 1, 1, 0);
    idle(3); burst(1); burst(1);

    // R4 swap one cycle before the burst: late flag, old order
    phase = "R4";
    step(0, 1, 1, 4'h7, 0, 0, 0);
    step(0, 1, 1, 4'h8, 1, 1, 0);
    burst(1); burst(1);
    idle(3);

    // R6 swaps while disabled are ignored
    phase = "R6";
    step(0, 0, 1, 4'hA, 0, 1, 0);
    step(0, 0, 1, 4'hB, 1, 1, 0);
    idle(3); burst(0); burst(0);

    // R7 orphan beat, then state must be unchanged
    phase = "R7";
    step(0, 1, 0, '0, 0, 0, 1);
    step(0, 1, 1, 4'hC, 1, 0, 0);
    burst(1);

    // R9 overflow, then issue alongside retirement
    phase = "R9";
    step(0, 1, 1, 4'h1, 0, 0, 0);
    step(0, 1, 1, 4'h2, 0, 0, 0);
    step(0, 1, 1, 4'hF, 1, 0, 0);
    for (int i = 0; i < BEATS - 1; i++) step(0, 1, 0, '0, 0, 0, 1);
    step(0, 1, 1, 4'hE, 1, 0, 1);
    burst(1); burst(1);

    // R11 swap mid-burst keeps the burst on one request
    phase = "R11";
    step(0, 1, 1, 4'h4, 0, 0, 0);
    step(0, 1, 1, 4'h5, 1, 0, 0);
    step(0, 1, 0, '0, 0, 0, 1);
    step(0, 1, 0, '0, 0, 1, 1);
    step(0, 1, 0, '0, 0, 0, 1);
    step(0, 1, 0, '0, 0, 0, 1);
    burst(1);

    // R10 reset in the middle of activity
    phase = "R10";
    step(0, 1, 1, 4'h3, 0, 1, 0);
    step(0, 1, 1, 4'h4, 0, 0, 1);
    step(1, 1, 0, '0, 0, 0, 0);
    @(negedge clk); #2;
    chk("R10", "outstanding", outstanding, 0);
    step(0, 1, 1, 4'h6, 1, 0, 0);
    idle(2); burst(1);

    // constrained random mix
    phase = "R3";
    void'($urandom(32'd7));
    for (int n = 0; n < 4000; n++) begin
      logic r_rst, r_en, r_iss, r_ins, r_sw, r_dv;
      r_rst = ($urandom_range(0, 299) == 0);
      r_en  = ($urandom_range(0, 7) != 0);
      r_iss = ($urandom_range(0, 3) == 0);
      r_ins = $urandom_range(0, 1);
      r_sw  = ($urandom_range(0, 7) == 0);
      r_dv  = (mbeat != 0) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 2) == 0);
      step(r_rst, r_en, r_iss, TAG_W'($urandom), r_ins, r_sw, r_dv);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule